// File: doc/BRIEF.md
# Wiper Tap Register with Stored-Value Recall

This block owns the 7-bit tap code that positions a digitally controlled potentiometer wiper. Code 00h places the wiper at the low end of the resistor string and 7Fh at the high end. The block sits behind an already decoded serial-bus slave. It sees each byte's full address, a strobe at the moment the last data bit is clocked in, a strobe when the whole byte is accepted, and read requests. It answers with read data and with a pulse telling the memory controller that the accepted byte must be committed to non-volatile storage.

At power-up the tap code is forced to mid-scale (40h). The block then waits for a supply-good indication and asks the non-volatile store for the saved initial value through a request/acknowledge handshake. When the value arrives, it is placed in the tap code and the block starts serving the bus. Until then, every bus event is ignored.

The two top addresses of the map belong to this block. The highest address (7FFh) reaches the tap code and a local copy of the saved initial value. The next one down (7FEh) holds a volatile-only flag in bit 7. That flag chooses whether 7FFh reads the live code or the saved value, and whether a write goes to the live code alone or to both. The two addresses below 7FEh are reserved. Everything lower is general memory held elsewhere.

Top module: `tap_keeper`

## Requirements
- R1: While `rst` is high and after it is released, `tap_code` is 40h, the volatile-only flag is 0, and `ready` and `rcl_req` are 0 until `pwr_ok` is seen.
- R2: One cycle after `pwr_ok` is sampled high, `rcl_req` is 1. In the cycle after `rcl_ack` is sampled high, `tap_code` equals `rcl_data[6:0]`, `ready` is 1 and `rcl_req` is 0. `rcl_req` is never 1 while `ready` is 1.
- R3: Before `ready`, bit, write and read strobes have no effect: `tap_code` stays 40h, `rd_vld` and `nv_req` stay 0.
- R4: A `bit_last_stb` with `bus_addr` = 7FFh loads `wr_data[6:0]` into `tap_code`, visible the next cycle. This does not wait for `wr_stb`.
- R5: A `wr_stb` to 7FEh whose `wr_data[6:0]` is zero sets the flag to `wr_data[7]`. If any of bits 6..0 is nonzero, the write is ignored. A read of 7FEh returns {flag, 7'b0}.
- R6: A `rd_req` is answered in the next cycle with `rd_vld` = 1. At 7FFh, `rd_data` is the live `tap_code` when the flag is 1 and the saved initial value when it is 0.
- R7: A `wr_stb` to 7FFh with the flag at 0 updates the saved initial value and pulses `nv_req`. With the flag at 1, the saved value is unchanged and `nv_req` stays 0.
- R8: `nv_req` is a one-cycle pulse in the cycle after a `wr_stb` to an address below 7FCh. It is not raised for writes to 7FCh, 7FDh or 7FEh.
- R9: Writes to 7FCh and 7FDh change nothing. Reads of 7FCh, 7FDh and of general memory addresses return 00h.
- R10: Bit 7 of a byte written to 7FFh is discarded, and bit 7 of a byte read from 7FFh is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| pwr_ok | input | 1 | Supply high enough to read the non-volatile store |
| rcl_req | output | 1 | Request for the saved initial value |
| rcl_ack | input | 1 | Saved value present on `rcl_data` |
| rcl_data | input | 8 | Saved initial value byte |
| bus_addr | input | 11 | Full byte address of the current bus access |
| bit_last_stb | input | 1 | Last data bit of a write byte has been clocked in |
| wr_stb | input | 1 | Write byte accepted |
| wr_data | input | 8 | Write byte |
| rd_req | input | 1 | Read request for `bus_addr` |
| rd_vld | output | 1 | `rd_data` valid |
| rd_data | output | 8 | Read byte |
| nv_req | output | 1 | Accepted byte must be committed to non-volatile storage |
| ready | output | 1 | Recall done, bus events accepted |
| tap_code | output | 7 | Wiper tap code |

## Verification
The flag-dependent path is tried in both flag states, with writes and reads of 7FFh interleaved. This separates a design that routes reads from the live code from one that routes them from the saved copy, and shows whether a live-only write leaks into the saved value or raises a commit. Control-byte patterns with a clean top bit and with a dirty low bit show whether the flag is qualified. Writes to the reserved and general addresses show the commit rule and that the tap is left alone. Bus traffic before the recall completes, and the extreme codes 00h and 7Fh, cover the boundaries.

// File: rtl/tap_pkg.sv
package tap_pkg;
  typedef enum logic [1:0] {
    BOOT_IDLE  = 2'd0,
    BOOT_FETCH = 2'd1,
    BOOT_RUN   = 2'd2
  } boot_st_t;

  typedef struct packed {
    logic top;  // live tap / saved value
    logic ctl;  // volatile-only flag byte
    logic rsv;  // reserved window
    logic gp;   // general memory below the window
  } addr_cls_t;
endpackage

// File: rtl/tap_addr_dec.sv
module tap_addr_dec
  import tap_pkg::*;
#(
  parameter int AW      = 11,
  parameter int RSV_CNT = 2
) (
  input  logic [AW-1:0] addr,
  output addr_cls_t     cls
);
  localparam logic [AW-1:0] A_TOP = {AW{1'b1}};
  localparam logic [AW-1:0] A_CTL = A_TOP - 1'b1;
  localparam logic [AW-1:0] A_LOW = A_CTL - AW'(RSV_CNT);

  assign cls.top = (addr == A_TOP);
  assign cls.ctl = (addr == A_CTL);
  assign cls.gp  = (addr < A_LOW);

  generate
    if (RSV_CNT == 0) begin : g_no_rsv
      assign cls.rsv = 1'b0;
    end else begin : g_rsv
      assign cls.rsv = (addr >= A_LOW) && (addr < A_CTL);
    end
  endgenerate
endmodule

// File: rtl/tap_boot_seq.sv
module tap_boot_seq
  import tap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic rcl_ack,
  output logic rcl_req,
  output logic ready,
  output logic boot_load
);
  boot_st_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= BOOT_IDLE;
    end else begin
      unique case (st)
        BOOT_IDLE:  if (pwr_ok)  st <= BOOT_FETCH;
        BOOT_FETCH: if (rcl_ack) st <= BOOT_RUN;
        default:    st <= BOOT_RUN;
      endcase
    end
  end

  assign rcl_req   = (st == BOOT_FETCH);
  assign ready     = (st == BOOT_RUN);
  assign boot_load = (st == BOOT_FETCH) && rcl_ack;
endmodule

// File: rtl/tap_store.sv
module tap_store #(
  parameter int TW  = 7,
  parameter int MID = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boot_load,
  input  logic [TW-1:0] boot_val,
  input  logic          live_load,
  input  logic [TW-1:0] live_val,
  input  logic          copy_we,
  input  logic [TW-1:0] copy_val,
  input  logic          flag_we,
  input  logic          flag_d,
  output logic [TW-1:0] tap,
  output logic [TW-1:0] stored,
  output logic          flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tap    <= TW'(MID);
      stored <= TW'(MID);
      flag   <= 1'b0;
    end else begin
      if (boot_load) begin
        tap    <= boot_val;
        stored <= boot_val;
      end else begin
        if (live_load) tap <= live_val;
        if (copy_we)   stored <= copy_val;
      end
      if (flag_we) flag <= flag_d;
    end
  end
endmodule

// File: rtl/tap_keeper.sv
module tap_keeper
  import tap_pkg::*;
#(
  parameter int AW      = 11,
  parameter int DW      = 8,
  parameter int TW      = 7,
  parameter int MID     = 64,
  parameter int RSV_CNT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_ok,
  output logic          rcl_req,
  input  logic          rcl_ack,
  input  logic [DW-1:0] rcl_data,
  input  logic [AW-1:0] bus_addr,
  input  logic          bit_last_stb,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  output logic          rd_vld,
  output logic [DW-1:0] rd_data,
  output logic          nv_req,
  output logic          ready,
  output logic [TW-1:0] tap_code
);
  localparam int PADW = DW - TW;

  addr_cls_t     cls;
  logic          boot_load;
  logic [TW-1:0] stored;
  logic          flag;
  logic          live_load, copy_we, flag_we, commit;
  logic [DW-1:0] rd_next;
  logic          rcl_msb_unused;

  assign rcl_msb_unused = rcl_data[DW-1];

  tap_addr_dec #(.AW(AW), .RSV_CNT(RSV_CNT)) dec_i (
    .addr (bus_addr),
    .cls  (cls)
  );

  tap_boot_seq boot_i (
    .clk       (clk),
    .rst       (rst),
    .pwr_ok    (pwr_ok),
    .rcl_ack   (rcl_ack),
    .rcl_req   (rcl_req),
    .ready     (ready),
    .boot_load (boot_load)
  );

  // live code moves on the last-bit strobe, the rest on byte accept
  assign live_load = ready && bit_last_stb && cls.top;
  assign copy_we   = ready && wr_stb && cls.top && !flag;
  assign flag_we   = ready && wr_stb && cls.ctl && (wr_data[DW-2:0] == '0);
  assign commit    = ready && wr_stb && (cls.gp || (cls.top && !flag));

  tap_store #(.TW(TW), .MID(MID)) store_i (
    .clk       (clk),
    .rst       (rst),
    .boot_load (boot_load),
    .boot_val  (rcl_data[TW-1:0]),
    .live_load (live_load),
    .live_val  (wr_data[TW-1:0]),
    .copy_we   (copy_we),
    .copy_val  (wr_data[TW-1:0]),
    .flag_we   (flag_we),
    .flag_d    (wr_data[DW-1]),
    .tap       (tap_code),
    .stored    (stored),
    .flag      (flag)
  );

  always_comb begin
    rd_next = '0;
    if (cls.top)      rd_next = {{PADW{1'b0}}, (flag ? tap_code : stored)};
    else if (cls.ctl) rd_next = {flag, {(DW-1){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld  <= 1'b0;
      rd_data <= '0;
      nv_req  <= 1'b0;
    end else begin
      rd_vld <= ready && rd_req;
      if (ready && rd_req) rd_data <= rd_next;
      nv_req <= commit;
    end
  end
endmodule

// File: rtl/tap_keeper_chk.sv
module tap_keeper_chk #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int TW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          ready,
  input logic          rcl_req,
  input logic          rcl_ack,
  input logic          bit_last_stb,
  input logic          wr_stb,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] wr_data,
  input logic          rd_req,
  input logic          rd_vld,
  input logic [DW-1:0] rd_data,
  input logic          nv_req,
  input logic [TW-1:0] tap_code
);
  localparam logic [AW-1:0] C_TOP = {AW{1'b1}};
  localparam logic [AW-1:0] C_CTL = C_TOP - 1'b1;

  // R2
  req_excl_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rcl_req |-> !ready);

  // R3
  boot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready && !rcl_ack) |=> $stable(tap_code));

  // R4
  early_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && bit_last_stb && bus_addr == C_TOP) |=> tap_code == $past(wr_data[TW-1:0]));

  // R5
  ctl_read_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && rd_req && bus_addr == C_CTL) |=> rd_data[DW-2:0] == '0);

  // R6
  rd_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> $past(rd_req && ready));

  // R8
  ctl_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && wr_stb && bus_addr == C_CTL) |=> !nv_req);

  // R10
  top_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && rd_req && bus_addr == C_TOP) |=> !rd_data[DW-1]);
endmodule

bind tap_keeper tap_keeper_chk #(.AW(AW), .DW(DW), .TW(TW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .ready        (ready),
  .rcl_req      (rcl_req),
  .rcl_ack      (rcl_ack),
  .bit_last_stb (bit_last_stb),
  .wr_stb       (wr_stb),
  .bus_addr     (bus_addr),
  .wr_data      (wr_data),
  .rd_req       (rd_req),
  .rd_vld       (rd_vld),
  .rd_data      (rd_data),
  .nv_req       (nv_req),
  .tap_code     (tap_code)
);

// File: tb/tap_keeper_tb_top.sv
module tap_keeper_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_ok = 1'b0;
  logic        rcl_req;
  logic        rcl_ack = 1'b0;
  logic [7:0]  rcl_data = 8'h00;
  logic [10:0] bus_addr = 11'h000;
  logic        bit_last_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_req = 1'b0;
  logic        rd_vld;
  logic [7:0]  rd_data;
  logic        nv_req;
  logic        ready;
  logic [6:0]  tap_code;

  int vectors = 0;
  int errs = 0;
  int cyc = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_keeper dut_i (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .rcl_req(rcl_req),
    .rcl_ack(rcl_ack), .rcl_data(rcl_data), .bus_addr(bus_addr),
    .bit_last_stb(bit_last_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_req(rd_req), .rd_vld(rd_vld), .rd_data(rd_data),
    .nv_req(nv_req), .ready(ready), .tap_code(tap_code)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected byte per valid read
  always @(negedge clk) begin
    if (!rst && rd_vld) begin
      if (exp_q.size() == 0) begin
        vectors++; errs++;
        $display("FAIL R3/R6 unexpected read actual=%h expected=none", rd_data);
      end else begin
        chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errs++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  task automatic do_read(input logic [10:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic do_write(input logic [10:0] a, input logic [7:0] d, output logic nv);
    @(negedge clk);
    bus_addr = a; wr_data = d; bit_last_stb = 1'b1;
    @(negedge clk);
    bit_last_stb = 1'b0; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    nv = nv_req;
  endtask

  initial begin
    logic nv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tap after reset", {1'b0, tap_code}, 8'h40);
    chk("R1 ready low", {7'b0, ready}, 8'h00);
    chk("R1 rcl_req low", {7'b0, rcl_req}, 8'h00);

    // R3 traffic before recall is ignored
    do_write(11'h7FF, 8'h11, nv);
    chk("R3 tap unchanged", {1'b0, tap_code}, 8'h40);
    chk("R3 no commit", {7'b0, nv}, 8'h00);
    do_write(11'h100, 8'h22, nv);
    chk("R3 no commit gp", {7'b0, nv}, 8'h00);
    @(negedge clk); bus_addr = 11'h7FF; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    @(negedge clk);

    // R2 recall handshake
    pwr_ok = 1'b1;
    @(negedge clk);
    chk("R2 rcl_req raised", {7'b0, rcl_req}, 8'h01);
    chk("R2 not ready yet", {7'b0, ready}, 8'h00);
    rcl_ack = 1'b1; rcl_data = 8'hA5;
    @(negedge clk);
    rcl_ack = 1'b0;
    chk("R2 tap recalled", {1'b0, tap_code}, 8'h25);
    chk("R2 ready", {7'b0, ready}, 8'h01);
    chk("R2 rcl_req dropped", {7'b0, rcl_req}, 8'h00);

    // R6 flag 0: saved value read back
    do_read(11'h7FF, 8'h25, "R6 saved read flag0");
    do_read(11'h7FE, 8'h00, "R5 flag reset 0");

    // R7 R10 write with flag 0
    do_write(11'h7FF, 8'h93, nv);
    chk("R10 msb dropped on tap", {1'b0, tap_code}, 8'h13);
    chk("R7 commit flag0", {7'b0, nv}, 8'h01);
    @(negedge clk);
    chk("R8 pulse one cycle", {7'b0, nv_req}, 8'h00);
    do_read(11'h7FF, 8'h13, "R10 R7 saved updated");

    // R5 set flag
    do_write(11'h7FE, 8'h80, nv);
    chk("R8 no commit ctl", {7'b0, nv}, 8'h00);
    do_read(11'h7FE, 8'h80, "R5 flag set");

    // R7 flag 1: live only
    do_write(11'h7FF, 8'h7F, nv);
    chk("R7 tap top code", {1'b0, tap_code}, 8'h7F);
    chk("R7 no commit flag1", {7'b0, nv}, 8'h00);
    do_read(11'h7FF, 8'h7F, "R6 live read flag1");

    // R5 dirty control byte ignored
    do_write(11'h7FE, 8'h81, nv);
    do_read(11'h7FE, 8'h80, "R5 dirty write ignored");
    do_write(11'h7FE, 8'h00, nv);
    do_read(11'h7FE, 8'h00, "R5 flag cleared");
    do_read(11'h7FF, 8'h13, "R7 saved untouched by flag1 write");
    chk("R6 tap kept", {1'b0, tap_code}, 8'h7F);

    // R4 strobe alone loads the live code
    @(negedge clk);
    bus_addr = 11'h7FF; wr_data = 8'h00; bit_last_stb = 1'b1;
    @(negedge clk);
    bit_last_stb = 1'b0;
    chk("R4 early load zero code", {1'b0, tap_code}, 8'h00);
    do_read(11'h7FF, 8'h13, "R4 strobe leaves saved value");

    // R9 reserved and general addresses
    do_write(11'h7FD, 8'h55, nv);
    chk("R9 reserved no commit", {7'b0, nv}, 8'h00);
    chk("R9 reserved tap kept", {1'b0, tap_code}, 8'h00);
    do_write(11'h7FC, 8'h80, nv);
    do_read(11'h7FE, 8'h00, "R9 reserved write no flag");
    do_read(11'h7FD, 8'h00, "R9 reserved read zero");
    do_write(11'h7FB, 8'h44, nv);
    chk("R8 commit top gp", {7'b0, nv}, 8'h01);
    do_write(11'h123, 8'h44, nv);
    chk("R8 commit gp", {7'b0, nv}, 8'h01);
    chk("R9 gp tap kept", {1'b0, tap_code}, 8'h00);
    do_read(11'h123, 8'h00, "R9 gp read zero");

    // R1 second reset
    @(negedge clk); rst = 1'b1; pwr_ok = 1'b0;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 tap after re-reset", {1'b0, tap_code}, 8'h40);
    chk("R1 ready after re-reset", {7'b0, ready}, 8'h00);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      vectors++; errs++;
      $display("FAIL R6 missing reads actual=%0d expected=0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule